// File: doc/BRIEF.md
# System Exception Pending Register

This block holds the pending state of three system exceptions: the non-maskable interrupt, the pendable service request and the periodic tick exception. Software changes that state through one 32-bit write port, in which separate bits set and clear each exception. The tick timer can also mark the tick exception pending with a one-cycle pulse. When the core accepts an exception, the exception logic sends a one-cycle hardware clear pulse for it.

The same block assembles a 32-bit status word for software to read. The word holds the three pending bits together with vector information supplied by the surrounding interrupt logic: the active vector, a return-to-base indication, the highest pending vector and a flag for any pending external interrupt. Vectors 0 to 15 are system exceptions, and external interrupt n is vector 16+n. Priority arbitration and vector fetch take place outside this block.

Top module: `sysexc_pend_ctl`

## Requirements
- R1: A synchronous active-high reset clears all three pending bits, so status bits 31, 28 and 26 read 0 after the first clock edge with `rst` high.
- R2: A write with bit 31 set makes the non-maskable interrupt pending. Status bit 31 and `pend_nmi` show that state. There is no software clear for it.
- R3: A write with bit 28 set makes the service request pending. A write with bit 27 set clears it only when bit 28 is 0 in the same write. The state shows on status bit 28 and `pend_svc`.
- R4: A write with bit 26 set, or a `tick_req` pulse, makes the tick exception pending. A write with bit 25 set clears it only when no set of the tick exception occurs in the same cycle. The state shows on status bit 26 and `pend_tick`.
- R5: `hw_clr[0]`, `hw_clr[1]` and `hw_clr[2]` clear the NMI, service and tick pending bits. A set of the same exception in the same cycle takes precedence over the clear.
- R6: Zero bits in a write have no effect. While `wr_en` is low, `wr_data` has no effect.
- R7: Status bits 8:0 equal `act_vec`. The encoding 0 means that no exception is active.
- R8: Status bit 11 (return to base) is 1 when `act_vec` is 0 or when `act_single` is 1. Otherwise it is 0.
- R9: Status bits 20:12 equal `top_pend_vec` (0 = nothing pending), and status bit 22 equals `ext_pend_any`. Bits 10:9, 21, 25:23, 27 and 30:29 read 0.
- R10: A change to a pending bit appears in the status word and on the pending outputs right after the clock edge that samples it. The vector fields follow their inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word: set/clear bits 31, 28, 27, 26, 25 |
| tick_req | input | 1 | Timer pulse that sets tick pending |
| hw_clr | input | 3 | Acknowledge clears: [0] NMI, [1] service, [2] tick |
| act_vec | input | 9 | Active vector number, 0 when none |
| act_single | input | 1 | Exactly one exception is active |
| top_pend_vec | input | 9 | Highest pending vector, 0 when none |
| ext_pend_any | input | 1 | Some external interrupt is pending |
| status_word | output | 32 | Composed interrupt control/state word |
| pend_nmi | output | 1 | NMI pending |
| pend_svc | output | 1 | Service request pending |
| pend_tick | output | 1 | Tick exception pending |

## Verification
A wrong pending bit shows on its dedicated output and on the matching status bit one edge after the write, pulse or clear that caused it. It stays visible until a later command changes that bit, so every check samples just after the edge. The bench drives the conflicting cases: a set and a clear in the same write, a software clear with a timer pulse, and a hardware clear with a software set. If precedence is reversed in any of these, the result is wrong on the very next cycle. A wrong vector field or return-to-base bit shows in the same cycle as the input change.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;

    parameter int WORD_W  = 32;
    parameter int VEC_W   = 9;
    parameter int NUM_EXC = 3;

    // write-side command bits
    localparam int NMI_SET_BIT  = 31;
    localparam int SVC_SET_BIT  = 28;
    localparam int SVC_CLR_BIT  = 27;
    localparam int TICK_SET_BIT = 26;
    localparam int TICK_CLR_BIT = 25;

    // read-side field positions
    localparam int ACT_LSB  = 0;
    localparam int RTB_BIT  = 11;
    localparam int PVEC_LSB = 12;
    localparam int EXTP_BIT = 22;

    typedef enum int unsigned {
        EXC_NMI  = 0,
        EXC_SVC  = 1,
        EXC_TICK = 2
    } exc_e;

    typedef struct packed {
        logic [NUM_EXC-1:0] set;
        logic [NUM_EXC-1:0] clr;
    } pend_cmd_t;

    typedef struct packed {
        logic [VEC_W-1:0] act_vec;
        logic             act_single;
        logic [VEC_W-1:0] pend_vec;
        logic             ext_pend;
    } vec_info_t;

    function automatic logic [WORD_W-1:0] pack_status(vec_info_t v, logic [NUM_EXC-1:0] pend);
        logic [WORD_W-1:0] w;
        w = '0;
        w[ACT_LSB +: VEC_W]  = v.act_vec;
        w[RTB_BIT]           = (v.act_vec == '0) | v.act_single;
        w[PVEC_LSB +: VEC_W] = v.pend_vec;
        w[EXTP_BIT]          = v.ext_pend;
        w[NMI_SET_BIT]       = pend[EXC_NMI];
        w[SVC_SET_BIT]       = pend[EXC_SVC];
        w[TICK_SET_BIT]      = pend[EXC_TICK];
        return w;
    endfunction

endpackage

// File: rtl/sysexc_wr_decode.sv
module sysexc_wr_decode
    import sysexc_pkg::*;
(
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              tick_req,
    input  logic [NUM_EXC-1:0] hw_clr,
    output pend_cmd_t         cmd
);
    logic sw_nmi_set, sw_svc_set, sw_svc_clr, sw_tick_set, sw_tick_clr;
    logic unused_bits;

    assign sw_nmi_set  = wr_en & wr_data[NMI_SET_BIT];
    assign sw_svc_set  = wr_en & wr_data[SVC_SET_BIT];
    assign sw_svc_clr  = wr_en & wr_data[SVC_CLR_BIT];
    assign sw_tick_set = wr_en & wr_data[TICK_SET_BIT];
    assign sw_tick_clr = wr_en & wr_data[TICK_CLR_BIT];
    assign unused_bits = ^{wr_data[30:29], wr_data[24:0]};

    always_comb begin
        cmd = '0;
        cmd.set[EXC_NMI]  = sw_nmi_set;
        cmd.set[EXC_SVC]  = sw_svc_set;
        cmd.set[EXC_TICK] = sw_tick_set | tick_req;
        cmd.clr[EXC_NMI]  = hw_clr[EXC_NMI];
        cmd.clr[EXC_SVC]  = hw_clr[EXC_SVC] | sw_svc_clr;
        cmd.clr[EXC_TICK] = hw_clr[EXC_TICK] | sw_tick_clr;
    end

endmodule

// File: rtl/sysexc_pend_bit.sv
module sysexc_pend_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    // set has precedence over clear
    always_ff @(posedge clk) begin
        if (rst)
            pend_o <= 1'b0;
        else if (set_i)
            pend_o <= 1'b1;
        else if (clr_i)
            pend_o <= 1'b0;
    end
endmodule

// File: rtl/sysexc_status_pack.sv
module sysexc_status_pack
    import sysexc_pkg::*;
(
    input  vec_info_t          vinfo,
    input  logic [NUM_EXC-1:0] pend,
    output logic [WORD_W-1:0]  word
);
    assign word = pack_status(vinfo, pend);
endmodule

// File: rtl/sysexc_pend_ctl.sv
module sysexc_pend_ctl
    import sysexc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              tick_req,
    input  logic [2:0]        hw_clr,
    input  logic [8:0]        act_vec,
    input  logic              act_single,
    input  logic [8:0]        top_pend_vec,
    input  logic              ext_pend_any,
    output logic [31:0]       status_word,
    output logic              pend_nmi,
    output logic              pend_svc,
    output logic              pend_tick
);
    pend_cmd_t          cmd;
    logic [NUM_EXC-1:0] pend;
    vec_info_t          vinfo;

    sysexc_wr_decode u_dec (
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .tick_req (tick_req),
        .hw_clr   (hw_clr),
        .cmd      (cmd)
    );

    for (genvar i = 0; i < NUM_EXC; i++) begin : g_pend
        sysexc_pend_bit u_bit (
            .clk    (clk),
            .rst    (rst),
            .set_i  (cmd.set[i]),
            .clr_i  (cmd.clr[i]),
            .pend_o (pend[i])
        );
    end

    always_comb begin
        vinfo.act_vec    = act_vec;
        vinfo.act_single = act_single;
        vinfo.pend_vec   = top_pend_vec;
        vinfo.ext_pend   = ext_pend_any;
    end

    sysexc_status_pack u_pack (
        .vinfo (vinfo),
        .pend  (pend),
        .word  (status_word)
    );

    assign pend_nmi  = pend[EXC_NMI];
    assign pend_svc  = pend[EXC_SVC];
    assign pend_tick = pend[EXC_TICK];

endmodule

// File: rtl/sysexc_pend_chk.sv
module sysexc_pend_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        tick_req,
    input logic [2:0]  hw_clr,
    input logic [8:0]  act_vec,
    input logic        act_single,
    input logic [8:0]  top_pend_vec,
    input logic        ext_pend_any,
    input logic [31:0] status_word,
    input logic        pend_nmi,
    input logic        pend_svc,
    input logic        pend_tick
);
    AST_RST_CLEAR: assert property (@(posedge clk) $past(rst) |-> !(pend_nmi | pend_svc | pend_tick)); // R1
    AST_NMI_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[31]) |=> pend_nmi); // R2
    AST_SVC_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[28]) |=> pend_svc); // R3
    AST_SVC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[27] && !wr_data[28]) |=> !pend_svc); // R3
    AST_TICK_SET: assert property (@(posedge clk) disable iff (rst)
        (tick_req || (wr_en && wr_data[26])) |=> pend_tick); // R4
    AST_TICK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[25] && !wr_data[26] && !tick_req) |=> !pend_tick); // R4
    AST_HW_CLR: assert property (@(posedge clk) disable iff (rst)
        (hw_clr[0] && !(wr_en && wr_data[31])) |=> !pend_nmi); // R5
    AST_NO_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((!wr_en || wr_data == 32'h0) && !tick_req && hw_clr == 3'b000)
        |=> $stable({pend_nmi, pend_svc, pend_tick})); // R6
    AST_RTB_IDLE: assert property (@(posedge clk) disable iff (rst)
        (act_vec == 9'd0) |-> status_word[11]); // R8
endmodule

bind sysexc_pend_ctl sysexc_pend_chk u_chk (.*);

// File: tb/tb_sysexc_pend_ctl.sv
module tb_sysexc_pend_ctl;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        tick_req;
    logic [2:0]  hw_clr;
    logic [8:0]  act_vec;
    logic        act_single;
    logic [8:0]  top_pend_vec;
    logic        ext_pend_any;
    logic [31:0] status_word;
    logic        pend_nmi, pend_svc, pend_tick;

    always #4 clk = ~clk;

    sysexc_pend_ctl dut (.*);

    typedef struct {
        logic [31:0] st;
        logic [2:0]  pn;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    logic m_nmi = 0, m_svc = 0, m_tick = 0;
    bit   done = 0;

    function automatic logic [31:0] exp_word(logic pn, logic ps, logic pt);
        logic [31:0] w = '0;
        w[8:0]   = act_vec;
        w[11]    = (act_vec == 9'd0) || act_single;
        w[20:12] = top_pend_vec;
        w[22]    = ext_pend_any;
        w[26]    = pt;
        w[28]    = ps;
        w[31]    = pn;
        return w;
    endfunction

    // driver: apply one cycle of stimulus, predict, push expectation
    task automatic step(input logic r, input logic we, input logic [31:0] d,
                        input logic tk, input logic [2:0] hc,
                        input logic [8:0] av, input logic as, input logic [8:0] pv,
                        input logic ex, input string tag);
        exp_t e;
        logic s_n, s_s, s_t, c_s, c_t;
        @(negedge clk);
        rst = r; wr_en = we; wr_data = d; tick_req = tk; hw_clr = hc;
        act_vec = av; act_single = as; top_pend_vec = pv; ext_pend_any = ex;
        s_n = we & d[31];
        s_s = we & d[28];
        s_t = (we & d[26]) | tk;
        c_s = (we & d[27]) | hc[1];
        c_t = (we & d[25]) | hc[2];
        if (r) begin
            m_nmi = 0; m_svc = 0; m_tick = 0;
        end else begin
            m_nmi  = s_n ? 1'b1 : (hc[0] ? 1'b0 : m_nmi);
            m_svc  = s_s ? 1'b1 : (c_s ? 1'b0 : m_svc);
            m_tick = s_t ? 1'b1 : (c_t ? 1'b0 : m_tick);
        end
        e.st  = exp_word(m_nmi, m_svc, m_tick);
        e.pn  = {m_nmi, m_svc, m_tick};
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: sample shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (status_word !== e.st || {pend_nmi, pend_svc, pend_tick} !== e.pn) begin
                    n_fail++;
                    $display("FAIL %s: status=%h pend=%b expected status=%h pend=%b",
                             e.tag, status_word, {pend_nmi, pend_svc, pend_tick}, e.st, e.pn);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    localparam logic [31:0] W_NMI = 32'h8000_0000;
    localparam logic [31:0] W_SVS = 32'h1000_0000;
    localparam logic [31:0] W_SVC = 32'h0800_0000;
    localparam logic [31:0] W_TKS = 32'h0400_0000;
    localparam logic [31:0] W_TKC = 32'h0200_0000;

    initial begin
        step(1, 0, 0, 0, 3'b000, 0, 0, 0, 0, "R1 reset");
        step(1, 1, W_NMI | W_SVS | W_TKS, 1, 3'b000, 0, 0, 0, 0, "R1 reset beats set");
        step(0, 0, 0, 0, 3'b000, 0, 0, 0, 0, "R1 idle after reset");
        step(0, 1, W_NMI, 0, 3'b000, 0, 0, 0, 0, "R2 nmi set");
        step(0, 0, 0, 0, 3'b001, 0, 0, 0, 0, "R5 nmi hw clear");
        step(0, 1, W_SVS, 0, 3'b000, 0, 0, 0, 0, "R3 svc set");
        step(0, 1, W_SVS | W_SVC, 0, 3'b000, 0, 0, 0, 0, "R3 svc set beats clear");
        step(0, 1, W_SVC, 0, 3'b000, 0, 0, 0, 0, "R3 svc clear");
        step(0, 1, W_SVC, 0, 3'b000, 0, 0, 0, 0, "R3 svc clear when idle");
        step(0, 0, 0, 1, 3'b000, 0, 0, 0, 0, "R4 tick pulse");
        step(0, 1, W_TKC, 1, 3'b000, 0, 0, 0, 0, "R4 pulse beats sw clear");
        step(0, 1, W_TKC, 0, 3'b000, 0, 0, 0, 0, "R4 tick clear");
        step(0, 1, W_TKS, 0, 3'b000, 0, 0, 0, 0, "R4 tick sw set");
        step(0, 1, W_TKS | W_TKC, 0, 3'b000, 0, 0, 0, 0, "R4 tick set beats clear");
        step(0, 1, W_NMI | W_SVS, 0, 3'b000, 0, 0, 0, 0, "R2 nmi and svc set");
        step(0, 1, 32'h0, 0, 3'b000, 0, 0, 0, 0, "R6 zero write");
        step(0, 0, 32'hFFFF_FFFF, 0, 3'b000, 0, 0, 0, 0, "R6 data without strobe");
        step(0, 1, W_NMI, 0, 3'b001, 0, 0, 0, 0, "R5 nmi set beats hw clear");
        step(0, 1, W_SVS, 0, 3'b010, 0, 0, 0, 0, "R5 svc set beats hw clear");
        step(0, 0, 0, 1, 3'b100, 0, 0, 0, 0, "R5 tick pulse beats hw clear");
        step(0, 0, 0, 0, 3'b110, 0, 0, 0, 0, "R5 svc tick hw clear");
        step(0, 0, 0, 0, 3'b001, 0, 0, 0, 0, "R10 nmi cleared next edge");
        step(0, 0, 0, 0, 3'b000, 9'd35, 0, 9'd0, 0, "R7 R8 active no base");
        step(0, 0, 0, 0, 3'b000, 9'd35, 1, 9'd0, 0, "R8 single active");
        step(0, 0, 0, 0, 3'b000, 9'd0, 1, 9'd0, 0, "R8 none active");
        step(0, 0, 0, 0, 3'b000, 9'd14, 0, 9'd511, 1, "R9 pend vec max ext");
        step(0, 0, 0, 0, 3'b000, 9'd511, 0, 9'd16, 0, "R7 R9 ext vector 0");
        step(0, 1, 32'h6FFF_FFFF & ~(W_SVC | W_TKC), 0, 3'b000, 9'd3, 0, 9'd2, 1, "R9 R6 reserved bits");
        step(0, 0, 0, 0, 3'b000, 0, 0, 0, 0, "R10 final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule